// File: doc/BRIEF.md
# Adaptive Auto-Precharge Decision Unit

This unit sits beside the command issue stage of a DRAM controller. When a read or write command leaves the controller, the unit decides whether that command should also close its row (auto-precharge). A two-bit page policy input chooses between four behaviours. Two of them are fixed: never close, or always close. The other two are adaptive. They look ahead at the requests still waiting in the scheduler that target the same bank, and decide from whether those requests would hit the open row.

To classify waiting requests as row hits or misses, the unit keeps one open-row record for each bank. An activate command loads the record with the new row. A read or write that carries auto-precharge marks the bank closed. The decision is purely combinational, so it is valid in the same cycle as the issue strobe. The records change on the following clock edge.

The waiting requests arrive as a flat snapshot: one valid bit, a bank field and a row field for each entry. The entry that is being issued is named by a slot index and does not take part in the look-ahead.

Top module: `apre_decider`

## Requirements
- R1: With `policy` = 0 (open), an issued read or write never carries auto-precharge.
- R2: With `policy` = 2 (closed), every issued read or write carries auto-precharge.
- R3: With `policy` = 1 (open-adaptive), auto-precharge is set only when at least one other waiting request targets the issued bank and none of those requests is a row hit.
- R4: With `policy` = 3 (closed-adaptive), auto-precharge is set when no other waiting request targets the issued bank, or when all such requests are row misses. It is clear when any of them is a row hit.
- R5: The look-ahead ignores three kinds of entry: entries whose valid bit is low, entries for other banks, and the entry at `issue_slot`.
- R6: A waiting request is a row hit only when its bank is open and its row equals the bank's recorded row. After reset every bank is closed, so every request is a miss.
- R7: An activate records `act_row` as the open row of `act_bank` from the next cycle on. The records of other banks are left unchanged.
- R8: An issued command that carries auto-precharge marks its bank closed from the next cycle on. If an activate to the same bank arrives in the same cycle, the activate wins.
- R9: `auto_pre` is combinational with `issue_valid` and is low whenever `issue_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; closes all banks |
| policy | input | 2 | Page policy: 0 open, 1 open-adaptive, 2 closed, 3 closed-adaptive |
| act_valid | input | 1 | Activate command strobe |
| act_bank | input | BANK_W | Bank being activated |
| act_row | input | ROW_W | Row being opened |
| issue_valid | input | 1 | Read/write issue strobe |
| issue_bank | input | BANK_W | Bank of the issued read/write |
| issue_slot | input | SLOT_W | Queue slot of the issued request, excluded from look-ahead |
| q_valid | input | QDEPTH | Valid bit of each waiting entry |
| q_bank | input | QDEPTH*BANK_W | Bank field of each entry, entry i at bits i*BANK_W |
| q_row | input | QDEPTH*ROW_W | Row field of each entry, entry i at bits i*ROW_W |
| auto_pre | output | 1 | Auto-precharge flag for the issued command |

## Verification
The decision itself settles within the cycle in which the inputs are applied. The bench therefore drives its inputs on the falling edge and samples `auto_pre` one time unit later. It drops `issue_valid` again before the next rising edge, so that a look-ahead probe does not change a bank record. Changes to the records (R6 to R8) are due one rising edge after the activate or issue that causes them. The bench lets exactly one rising edge pass with the command held, then checks the record by issuing a probe with an adaptive policy on the following falling edge.

// File: rtl/apre_decider.sv
module apre_decider #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int QDEPTH    = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int SLOT_W   = $clog2(QDEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                policy,
  input  logic                      act_valid,
  input  logic [BANK_W-1:0]         act_bank,
  input  logic [ROW_W-1:0]          act_row,
  input  logic                      issue_valid,
  input  logic [BANK_W-1:0]         issue_bank,
  input  logic [SLOT_W-1:0]         issue_slot,
  input  logic [QDEPTH-1:0]         q_valid,
  input  logic [QDEPTH*BANK_W-1:0]  q_bank,
  input  logic [QDEPTH*ROW_W-1:0]   q_row,
  output logic                      auto_pre
);

  logic [NUM_BANKS-1:0]       open_v;
  logic [ROW_W-1:0]           open_row [NUM_BANKS];
  logic [NUM_BANKS*ROW_W-1:0] open_row_flat;
  logic [QDEPTH-1:0]          same, hit;
  logic                       cur_open;
  logic [ROW_W-1:0]           cur_row;
  logic                       any_same, any_hit, decide;

  assign cur_open = open_v[issue_bank];
  assign cur_row  = open_row[issue_bank];

  for (genvar i = 0; i < QDEPTH; i++) begin : g_look
    assign same[i] = q_valid[i] && (issue_slot != SLOT_W'(i)) &&
                     (q_bank[i*BANK_W +: BANK_W] == issue_bank);
    assign hit[i]  = same[i] && cur_open && (q_row[i*ROW_W +: ROW_W] == cur_row);
  end

  assign any_same = |same;
  assign any_hit  = |hit;

  always_comb begin
    case (policy)
      2'd0:    decide = 1'b0;
      2'd1:    decide = any_same && !any_hit;
      2'd2:    decide = 1'b1;
      default: decide = !any_hit;
    endcase
  end

  assign auto_pre = issue_valid && decide;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic set_b, clr_b;
    assign set_b = act_valid && (act_bank == BANK_W'(b));
    assign clr_b = auto_pre && (issue_bank == BANK_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_v[b]   <= 1'b0;
        open_row[b] <= '0;
      end else if (set_b) begin
        open_v[b]   <= 1'b1;
        open_row[b] <= act_row;
      end else if (clr_b) begin
        open_v[b]   <= 1'b0;
      end
    end
    assign open_row_flat[b*ROW_W +: ROW_W] = open_row[b];
  end

endmodule

// File: rtl/apre_decider_chk.sv
module apre_decider_chk #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [1:0]                policy,
  input logic                      act_valid,
  input logic [BANK_W-1:0]         act_bank,
  input logic [ROW_W-1:0]          act_row,
  input logic                      issue_valid,
  input logic [BANK_W-1:0]         issue_bank,
  input logic                      auto_pre,
  input logic [NUM_BANKS-1:0]      open_v,
  input logic [NUM_BANKS*ROW_W-1:0] open_row_flat
);

  assert_open_never_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && policy == 2'd0) |-> !auto_pre);

  assert_closed_always_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && policy == 2'd2) |-> auto_pre);

  assert_reset_closed_R6: assert property (@(posedge clk)
    !rst_n |=> (open_v == '0));

  assert_act_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |=> (open_v[$past(act_bank)] &&
                   open_row_flat[$past(act_bank)*ROW_W +: ROW_W] == $past(act_row)));

  assert_pre_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_pre && !(act_valid && act_bank == issue_bank)) |=> !open_v[$past(issue_bank)]);

  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> !auto_pre);

endmodule

bind apre_decider apre_decider_chk #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .policy(policy), .act_valid(act_valid),
  .act_bank(act_bank), .act_row(act_row), .issue_valid(issue_valid),
  .issue_bank(issue_bank), .auto_pre(auto_pre), .open_v(open_v),
  .open_row_flat(open_row_flat)
);

// File: tb/tb_apre_decider.sv
module tb_apre_decider;
  localparam int NB = 8, RW = 14, QD = 8, BW = 3, SW = 3;

  logic clk = 0, rst_n = 0;
  logic [1:0] policy = 0;
  logic act_valid = 0, issue_valid = 0;
  logic [BW-1:0] act_bank = 0, issue_bank = 0;
  logic [RW-1:0] act_row = 0;
  logic [SW-1:0] issue_slot = 0;
  logic [QD-1:0] q_valid = 0;
  logic [QD*BW-1:0] q_bank = 0;
  logic [QD*RW-1:0] q_row = 0;
  logic auto_pre;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  apre_decider #(.NUM_BANKS(NB), .ROW_W(RW), .QDEPTH(QD)) dut (
    .clk(clk), .rst_n(rst_n), .policy(policy), .act_valid(act_valid),
    .act_bank(act_bank), .act_row(act_row), .issue_valid(issue_valid),
    .issue_bank(issue_bank), .issue_slot(issue_slot), .q_valid(q_valid),
    .q_bank(q_bank), .q_row(q_row), .auto_pre(auto_pre));

  task automatic check(input string req, input logic exp);
    checks++;
    if (auto_pre !== exp) begin
      errors++;
      $display("FAIL %s auto_pre=%b expected=%b", req, auto_pre, exp);
    end
  endtask

  task automatic clear_q();
    q_valid = 0; q_bank = 0; q_row = 0;
  endtask

  task automatic put(input int slot, input int bank, input int row);
    q_valid[slot] = 1'b1;
    q_bank[slot*BW +: BW] = BW'(bank);
    q_row[slot*RW +: RW] = RW'(row);
  endtask

  // probe: issue from slot 0 on bank b, sample, withdraw before the rising edge
  task automatic probe(input string req, input int pol, input int b, input logic exp);
    @(negedge clk);
    policy = 2'(pol); issue_bank = BW'(b); issue_slot = 0; issue_valid = 1;
    #1 check(req, exp);
    issue_valid = 0;
  endtask

  task automatic activate(input int b, input int row);
    @(negedge clk);
    act_valid = 1; act_bank = BW'(b); act_row = RW'(row);
    @(negedge clk);
    act_valid = 0;
  endtask

  task automatic t_reset();
    clear_q(); put(0, 0, 5); put(1, 0, 5);
    probe("R6 reset closed, CA", 3, 0, 1'b1);
    probe("R6 reset closed, OA", 1, 0, 1'b1);
  endtask

  task automatic t_fixed();
    activate(2, 'h100);
    clear_q(); put(0, 2, 'h100); put(3, 2, 'h200);
    probe("R1 open with miss queued", 0, 2, 1'b0);
    put(3, 2, 'h100);
    probe("R2 closed with hit queued", 2, 2, 1'b1);
    @(negedge clk); policy = 2; issue_valid = 0;
    #1 check("R9 no issue", 1'b0);
  endtask

  task automatic t_open_adaptive();
    clear_q(); put(0, 2, 'h100); put(3, 2, 'h100);
    probe("R3 hit queued", 1, 2, 1'b0);
    put(3, 2, 'h200);
    probe("R3 only misses", 1, 2, 1'b1);
    put(5, 2, 'h100);
    probe("R3 miss plus hit", 1, 2, 1'b0);
    clear_q(); put(0, 2, 'h100);
    probe("R3 R5 only issued slot", 1, 2, 1'b0);
    put(4, 5, 'h200);
    probe("R5 other bank ignored", 1, 2, 1'b0);
    put(6, 2, 'h300); q_valid[6] = 1'b0;
    probe("R5 invalid entry ignored", 1, 2, 1'b0);
  endtask

  task automatic t_closed_adaptive();
    clear_q(); put(0, 2, 'h100);
    probe("R4 R5 empty look-ahead", 3, 2, 1'b1);
    put(7, 2, 'h100);
    probe("R4 hit queued", 3, 2, 1'b0);
    put(7, 2, 'h111); put(2, 2, 'h222);
    probe("R4 all misses", 3, 2, 1'b1);
    put(1, 2, 'h100);
    probe("R4 misses plus hit", 3, 2, 1'b0);
    q_valid[1] = 1'b0;
    probe("R5 invalid hit ignored", 3, 2, 1'b1);
  endtask

  task automatic t_records();
    activate(1, 7);
    clear_q(); put(0, 2, 'h100); put(3, 2, 'h100);
    probe("R7 other bank kept", 3, 2, 1'b0);
    put(3, 1, 7); put(0, 1, 7);
    probe("R7 new bank open", 3, 1, 1'b0);
    // closed issue on bank 2 held across a rising edge
    clear_q(); put(0, 2, 'h100); put(3, 2, 'h100);
    @(negedge clk); policy = 2; issue_bank = 2; issue_slot = 0; issue_valid = 1;
    @(negedge clk); issue_valid = 0;
    probe("R8 R6 bank closed after precharge", 3, 2, 1'b1);
    activate(2, 'h200);
    put(3, 2, 'h200);
    probe("R7 reopened at new row", 3, 2, 1'b0);
    put(3, 2, 'h100);
    probe("R7 old row now miss", 3, 2, 1'b1);
    // activate and precharge on same bank in one cycle: activate wins
    @(negedge clk); policy = 2; issue_bank = 2; issue_valid = 1;
    act_valid = 1; act_bank = 2; act_row = 'h055;
    @(negedge clk); issue_valid = 0; act_valid = 0;
    put(3, 2, 'h055);
    probe("R8 activate wins", 3, 2, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_fixed();
        t_open_adaptive();
        t_closed_adaptive();
        t_records();
      end
      begin
        repeat (5000) @(negedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired got=running expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule